// File: doc/BRIEF.md
# Direct-Mapped Block Cache with Selectable Write Policy

This block is a direct-mapped data cache that sits between a processor's word port and a slower memory port. Each line holds a block of four consecutive 32-bit words, with one valid bit and one dirty bit. The processor presents one word read or write at a time, addressed by a 30-bit byte address. It holds the request until the cache raises `cpu_ready`. On a miss the cache stalls the processor and moves whole blocks over the memory port, one word for each req/ack beat.

A parameter selects the write policy. With `WRITE_BACK=1`, a write hit only touches the cache and marks the line dirty. A miss on a dirty line first copies the old block out to memory and then fetches the new one. With `WRITE_BACK=0`, every write goes to memory as a single word beat and also updates the cached copy. Lines are never dirty in that mode, so a block is never written back.

The request protocol on both ports is level-based. A transfer completes at the rising edge where request and ready (CPU side) or request and acknowledge (memory side) are both high. The requester keeps its address, direction and write data steady until then.

Top module: `blk_cache`

## Requirements
- R1: The address fields are: bits [1:0] are a byte offset that is ignored, bits [3:2] pick the word in the block, the next `INDEX_W` bits pick the line, and the remaining upper bits form the tag.
- R2: A read hit returns the word chosen by bits [3:2] with `cpu_ready` high in the same cycle as the request, and no memory beat is issued. `cpu_ready` is low whenever `cpu_req` is low.
- R3: A hit needs the line's valid bit set and its stored tag equal to the address tag. After reset every line is invalid, so the first access to any line misses.
- R4: A miss on a line that is not dirty fetches the four words of the new block in ascending word order, one read beat each. The access then completes as a hit in the cycle after the last beat.
- R5: On the memory port, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack`. Exactly one word moves per acknowledged beat.
- R6: In write-back mode, a write hit updates only the cache word, sets the line's dirty bit, completes in the same cycle and issues no memory beat.
- R7: In write-back mode, a miss on a valid dirty line first writes the old block's four words to the old tag's addresses and only then fetches the new block.
- R8: A refilled line is valid and clean, so a later miss that replaces it writes nothing back unless a write has dirtied it since the refill.
- R9: In write-through mode, a write hit sends the word to memory as one write beat. The same beat updates the cache, and `cpu_ready` rises in the cycle of the acknowledge.
- R10: In write-through mode, a write miss first fetches the block and then performs the single-word memory write. No block is ever written back in this mode.
- R11: Memory addresses are word aligned (bits [1:0] zero). `mem_we` is 0 on fetch beats and 1 on writeback and write-through beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = word write, 0 = word read |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when `cpu_ready` is high on a read |
| cpu_ready | output | 1 | Access completes at this edge; low = processor stalled |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Word-aligned byte address of the beat |
| mem_wdata | output | 32 | Data of a write beat |
| mem_rdata | input | 32 | Data returned with the acknowledge of a read beat |
| mem_ack | input | 1 | Beat acknowledge, one cycle per word |

## Verification
The bench pairs each cache with a memory model that acknowledges a beat one cycle after it sees the request, so every beat costs two cycles. The wait from the first request cycle to `cpu_ready` is then fixed by the requirements. A hit takes 0 cycles. A clean miss takes 1+2·4 = 9 cycles, and a dirty miss takes 1+2·8 = 17. A write-through write takes 2 more cycles than the read case: 2 on a hit, 11 on a miss. For each access the bench counts negative edges until ready and compares that count to the value its own line model predicts. It samples data and memory contents one step after the edge that completes the access. It also compares the number of read and write beats each access caused against what the requirements predict.

// File: rtl/blk_cache_pkg.sv
package blk_cache_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_OFF_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_WTWR  = 2'd3
  } cstate_e;
endpackage

// File: rtl/cache_word_pick.sv
module cache_word_pick #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32
) (
  input  logic [WORDS-1:0][WORD_W-1:0] line,
  input  logic [$clog2(WORDS)-1:0]     sel,
  output logic [WORD_W-1:0]            word
);
  localparam int SEL_W = $clog2(WORDS);

  logic [WORDS-1:0][WORD_W-1:0] masked;

  for (genvar g = 0; g < WORDS; g++) begin : g_mask
    assign masked[g] = (sel == SEL_W'(g)) ? line[g] : '0;
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < WORDS; i++) word = word | masked[i];
  end
endmodule

// File: rtl/cache_store.sv
module cache_store #(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 22,
  parameter int WORDS   = 4,
  parameter int WORD_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [INDEX_W-1:0]            idx,
  input  logic                          wr_en,
  input  logic [$clog2(WORDS)-1:0]      wr_sel,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic                          commit,
  input  logic [TAG_W-1:0]              commit_tag,
  input  logic                          set_dirty,
  output logic [TAG_W-1:0]              rd_tag,
  output logic                          rd_valid,
  output logic                          rd_dirty,
  output logic [WORDS-1:0][WORD_W-1:0]  rd_line
);
  localparam int LINES = 1 << INDEX_W;

  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [WORD_W-1:0] data_q  [LINES][WORDS];
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;

  assign rd_tag   = tag_q[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];

  always_comb begin
    for (int w = 0; w < WORDS; w++) rd_line[w] = data_q[idx][w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (commit) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end
      if (set_dirty) dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) tag_q[idx] <= commit_tag;
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[idx][wr_sel] <= wr_data;
  end

  // R8: a committed line is valid and clean on the next cycle
  a_r8_commit_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !set_dirty) |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)]));

  // R6: a dirty mark persists into the next cycle
  a_r6_dirty_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    set_dirty |=> dirty_q[$past(idx)]);
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import blk_cache_pkg::*;
#(
  parameter int ADDR_W     = 30,
  parameter int INDEX_W    = 4,
  parameter int WORDS      = 4,
  parameter bit WRITE_BACK = 1'b1,
  localparam int OFF_W     = $clog2(WORDS),
  localparam int IDX_LSB   = BYTE_OFF_W + OFF_W,
  localparam int TAG_LSB   = IDX_LSB + INDEX_W,
  localparam int TAG_W     = ADDR_W - TAG_LSB
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [WORD_W-1:0]            cpu_wdata,
  output logic                         cpu_ready,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [WORD_W-1:0]            mem_wdata,
  input  logic [WORD_W-1:0]            mem_rdata,
  input  logic                         mem_ack,
  input  logic [TAG_W-1:0]             lk_tag,
  input  logic                         lk_valid,
  input  logic                         lk_dirty,
  input  logic [WORD_W-1:0]            evict_word,
  output logic [INDEX_W-1:0]           st_idx,
  output logic                         st_wr_en,
  output logic [OFF_W-1:0]             st_wr_sel,
  output logic [WORD_W-1:0]            st_wr_data,
  output logic                         st_commit,
  output logic [TAG_W-1:0]             st_commit_tag,
  output logic                         st_set_dirty,
  output logic [OFF_W-1:0]             word_off,
  output logic [OFF_W-1:0]             beat
);
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:TAG_LSB];
  endfunction

  function automatic logic [INDEX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[TAG_LSB-1:IDX_LSB];
  endfunction

  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[IDX_LSB-1:BYTE_OFF_W];
  endfunction

  function automatic logic [ADDR_W-1:0] f_beat_addr(input logic [TAG_W-1:0] t,
                                                    input logic [INDEX_W-1:0] i,
                                                    input logic [OFF_W-1:0] b);
    return {t, i, b, {BYTE_OFF_W{1'b0}}};
  endfunction

  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

  cstate_e state_q, state_d;
  logic [OFF_W-1:0] beat_q;

  logic [TAG_W-1:0]   req_tag;
  logic [INDEX_W-1:0] req_idx;
  logic               hit;
  logic               victim_dirty;
  logic               beat_done;
  logic               block_done;

  assign req_tag      = f_tag(cpu_addr);
  assign req_idx      = f_idx(cpu_addr);
  assign word_off     = f_off(cpu_addr);
  assign hit          = lk_valid && (lk_tag == req_tag);
  assign victim_dirty = WRITE_BACK && lk_valid && lk_dirty;
  assign beat_done    = mem_req && mem_ack;
  assign block_done   = beat_done && (beat_q == LAST_BEAT);
  assign beat         = beat_q;
  assign st_idx       = req_idx;
  assign st_commit_tag = req_tag;

  always_comb begin
    state_d      = state_q;
    cpu_ready    = 1'b0;
    mem_req      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = '0;
    mem_wdata    = '0;
    st_wr_en     = 1'b0;
    st_wr_sel    = word_off;
    st_wr_data   = cpu_wdata;
    st_commit    = 1'b0;
    st_set_dirty = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (hit) begin
            if (!cpu_we) begin
              cpu_ready = 1'b1;
            end else if (WRITE_BACK) begin
              cpu_ready    = 1'b1;
              st_wr_en     = 1'b1;
              st_set_dirty = 1'b1;
            end else begin
              state_d = ST_WTWR;
            end
          end else begin
            state_d = victim_dirty ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = f_beat_addr(lk_tag, req_idx, beat_q);
        mem_wdata = evict_word;
        if (block_done) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        mem_addr = f_beat_addr(req_tag, req_idx, beat_q);
        if (beat_done) begin
          st_wr_en   = 1'b1;
          st_wr_sel  = beat_q;
          st_wr_data = mem_rdata;
        end
        if (block_done) begin
          st_commit = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      ST_WTWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cpu_addr & ~ADDR_W'(3);
        mem_wdata = cpu_wdata;
        if (beat_done) begin
          st_wr_en  = 1'b1;
          cpu_ready = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (beat_done && (state_q == ST_EVICT || state_q == ST_FILL))
        beat_q <= beat_q + 1'b1;
    end
  end

  // R5: an unacknowledged beat keeps its request and payload
  a_r5_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R2: the processor is released only with no beat pending, or on a write-through acknowledge
  a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (cpu_req && (!mem_req || (mem_we && mem_ack))));

  // R7: a writeback starts only from a valid dirty victim
  a_r7_evict_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVICT && $past(state_q) == ST_IDLE) |-> $past(lk_valid && lk_dirty));

  // R4: fill beats advance by one word per acknowledge
  a_r4_fill_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && mem_ack && beat_q != LAST_BEAT) |=>
      (state_q == ST_FILL && beat_q == $past(beat_q) + 1'b1));

  // R11: beats are word aligned
  a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  if (!WRITE_BACK) begin : g_wt_chk
    // R10: write-through never writes a block back
    a_r10_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != ST_EVICT);
  end
endmodule

// File: rtl/blk_cache.sv
module blk_cache
  import blk_cache_pkg::*;
#(
  parameter int ADDR_W     = 30,
  parameter int INDEX_W    = 4,
  parameter int WORDS      = 4,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - BYTE_OFF_W - OFF_W - INDEX_W;

  logic [TAG_W-1:0]                lk_tag;
  logic                            lk_valid;
  logic                            lk_dirty;
  logic [WORDS-1:0][WORD_W-1:0]    line;
  logic [WORD_W-1:0]               evict_word;
  logic [INDEX_W-1:0]              st_idx;
  logic                            st_wr_en;
  logic [OFF_W-1:0]                st_wr_sel;
  logic [WORD_W-1:0]               st_wr_data;
  logic                            st_commit;
  logic [TAG_W-1:0]                st_commit_tag;
  logic                            st_set_dirty;
  logic [OFF_W-1:0]                word_off;
  logic [OFF_W-1:0]                beat;

  cache_ctrl #(
    .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .WORDS(WORDS), .WRITE_BACK(WRITE_BACK)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .evict_word(evict_word),
    .st_idx(st_idx), .st_wr_en(st_wr_en), .st_wr_sel(st_wr_sel),
    .st_wr_data(st_wr_data), .st_commit(st_commit),
    .st_commit_tag(st_commit_tag), .st_set_dirty(st_set_dirty),
    .word_off(word_off), .beat(beat)
  );

  cache_store #(
    .INDEX_W(INDEX_W), .TAG_W(TAG_W), .WORDS(WORDS), .WORD_W(WORD_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .idx(st_idx),
    .wr_en(st_wr_en), .wr_sel(st_wr_sel), .wr_data(st_wr_data),
    .commit(st_commit), .commit_tag(st_commit_tag), .set_dirty(st_set_dirty),
    .rd_tag(lk_tag), .rd_valid(lk_valid), .rd_dirty(lk_dirty), .rd_line(line)
  );

  cache_word_pick #(.WORDS(WORDS), .WORD_W(WORD_W)) u_rd_pick (
    .line(line), .sel(word_off), .word(cpu_rdata)
  );

  cache_word_pick #(.WORDS(WORDS), .WORD_W(WORD_W)) u_ev_pick (
    .line(line), .sel(beat), .word(evict_word)
  );
endmodule

// File: tb/tb_blk_cache.sv
module tb_mem (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [29:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        ack
);
  logic [31:0] mem [4096];
  int nrd;
  int nwr;
  int nbad;

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h0001_0003) ^ 32'hC0DE_0000;
  endfunction

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    nrd = 0; nwr = 0; nbad = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= req && !ack;
      if (req && !ack) begin
        if (addr[1:0] != 2'b00) nbad <= nbad + 1;
        if (we) begin
          mem[addr[13:2]] <= wdata;
          nwr <= nwr + 1;
        end else begin
          rdata <= mem[addr[13:2]];
          nrd <= nrd + 1;
        end
      end
    end
  end
endmodule

module tb_blk_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req  [2];
  logic        we   [2];
  logic [29:0] addr [2];
  logic [31:0] wd   [2];
  logic [31:0] rd   [2];
  logic        rdy  [2];
  logic        mreq [2];
  logic        mwe  [2];
  logic [29:0] maddr[2];
  logic [31:0] mwd  [2];
  logic [31:0] mrd  [2];
  logic        mack [2];

  blk_cache #(.WRITE_BACK(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_we(we[0]), .cpu_addr(addr[0]),
    .cpu_wdata(wd[0]), .cpu_rdata(rd[0]), .cpu_ready(rdy[0]),
    .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]), .mem_wdata(mwd[0]),
    .mem_rdata(mrd[0]), .mem_ack(mack[0]));

  blk_cache #(.WRITE_BACK(1'b0)) dut_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(addr[1]),
    .cpu_wdata(wd[1]), .cpu_rdata(rd[1]), .cpu_ready(rdy[1]),
    .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]), .mem_wdata(mwd[1]),
    .mem_rdata(mrd[1]), .mem_ack(mack[1]));

  tb_mem mem0 (.clk(clk), .rst_n(rst_n), .req(mreq[0]), .we(mwe[0]), .addr(maddr[0]),
               .wdata(mwd[0]), .rdata(mrd[0]), .ack(mack[0]));
  tb_mem mem1 (.clk(clk), .rst_n(rst_n), .req(mreq[1]), .we(mwe[1]), .addr(maddr[1]),
               .wdata(mwd[1]), .rdata(mrd[1]), .ack(mack[1]));

  int tests = 0;
  int fails = 0;

  logic [31:0] shadow [int];
  logic [21:0] tagm [2][16];
  bit          valm [2][16];
  bit          dirm [2][16];

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h0001_0003) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [29:0] mk(input int t, input int i, input int w, input int b);
    return 30'((t << 8) | (i << 4) | (w << 2) | b);
  endfunction

  function automatic logic [31:0] expw(input int s, input logic [29:0] a);
    int k = s * 65536 + int'(a[15:2]);
    if (shadow.exists(k)) return shadow[k];
    return pat(int'(a[13:2]));
  endfunction

  function automatic logic [31:0] peek(input int s, input logic [29:0] a);
    if (s == 0) return mem0.mem[a[13:2]];
    return mem1.mem[a[13:2]];
  endfunction

  function automatic int nrd(input int s);
    return (s == 0) ? mem0.nrd : mem1.nrd;
  endfunction

  function automatic int nwr(input int s);
    return (s == 0) ? mem0.nwr : mem1.nwr;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic op(input int s, input bit w, input logic [29:0] a, input logic [31:0] d,
                    output logic [31:0] r, output int n);
    @(negedge clk);
    req[s] = 1'b1; we[s] = w; addr[s] = a; wd[s] = d; n = 0;
    #1;
    while (!rdy[s]) begin
      @(negedge clk);
      #1;
      n++;
    end
    r = rd[s];
    @(posedge clk);
    #1;
    req[s] = 1'b0; we[s] = 1'b0;
  endtask

  task automatic access(input int s, input bit w, input int t, input int i,
                        input int wo, input int b, input logic [31:0] d);
    logic [29:0] a = mk(t, i, wo, b);
    logic [31:0] r;
    logic [31:0] old_mem = peek(s, a);
    logic [21:0] vtag = tagm[s][i];
    int n;
    int lat = 0;
    int erd = 0;
    int ewr = 0;
    int rd0 = nrd(s);
    int wr0 = nwr(s);
    bit hit = valm[s][i] && (tagm[s][i] == 22'(t));
    bit dirty_miss = !hit && s == 0 && valm[s][i] && dirm[s][i];
    bit refilled_clean = !hit && valm[s][i] && !dirm[s][i];
    string tagr;
    if (!hit) begin
      lat = 9 + (dirty_miss ? 8 : 0);
      erd = 4;
      ewr = dirty_miss ? 4 : 0;
      tagm[s][i] = 22'(t); valm[s][i] = 1'b1; dirm[s][i] = 1'b0;
    end
    if (w) begin
      if (s == 0) dirm[s][i] = 1'b1;
      else begin lat += 2; ewr += 1; end
    end
    op(s, w, a, d, r, n);
    if (dirty_miss) tagr = "R7 dirty miss";
    else if (refilled_clean) tagr = "R8 clean victim";
    else if (!hit && !w) tagr = "R4/R3 read miss";
    else if (!hit) tagr = (s == 0) ? "R4 write-back write miss" : "R10 write-through write miss";
    else if (!w) tagr = (b != 0) ? "R1 byte offset ignored" : "R2 read hit";
    else tagr = (s == 0) ? "R6 write-back write hit" : "R9 write-through write hit";
    chk({tagr, " latency"}, 32'(n), 32'(lat));
    chk({tagr, " fetch beats"}, 32'(nrd(s) - rd0), 32'(erd));
    chk({tagr, " write beats"}, 32'(nwr(s) - wr0), 32'(ewr));
    if (!w) chk({tagr, " read data"}, r, expw(s, a));
    if (dirty_miss)
      for (int k = 0; k < 4; k++)
        chk("R7 written-back word", peek(s, mk(int'(vtag), i, k, 0)), expw(s, mk(int'(vtag), i, k, 0)));
    if (w) begin
      shadow[s * 65536 + int'(a[15:2])] = d;
      if (s == 0) chk("R6 memory untouched by write-back write", peek(s, a), old_mem);
      else chk("R9 memory holds write-through word", peek(s, a), d);
    end
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      req[s] = 0; we[s] = 0; addr[s] = '0; wd[s] = '0;
      for (int i = 0; i < 16; i++) begin valm[s][i] = 0; dirm[s][i] = 0; tagm[s][i] = '0; end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      chk("R2 reset ready low", 32'(rdy[s]), 32'd0);
      chk("R5 reset no beat", 32'(mreq[s]), 32'd0);
    end
    for (int s = 0; s < 2; s++) begin
      // R3/R4/R2: sweep every line and word of tag 1
      for (int i = 0; i < 16; i++)
        for (int w = 0; w < 4; w++) access(s, 1'b0, 1, i, w, 0, '0);
      // R1: byte offset bits do not change the word
      for (int b = 1; b < 4; b++) access(s, 1'b0, 1, 5, 2, b, '0);
      // R6/R9: write every word of tag 1
      for (int i = 0; i < 16; i++)
        for (int w = 0; w < 4; w++)
          access(s, 1'b1, 1, i, w, 0, 32'hA500_0000 | 32'((s << 12) | (i << 4) | w));
      // R7 (write-back) / R8, R10 (write-through): replace with tag 2
      for (int i = 0; i < 16; i++) access(s, 1'b0, 2, i, i % 4, 0, '0);
      // R8 / R10: write misses to tag 3 over clean tag-2 lines
      for (int i = 0; i < 16; i += 3) access(s, 1'b1, 3, i, 1, 0, 32'h3C00_0000 | 32'(i));
      // R7/R2: read tag 1 back, written values must return
      for (int i = 0; i < 16; i++) access(s, 1'b0, 1, i, 3 - (i % 4), 0, '0);
      chk("R11 misaligned beats", 32'((s == 0) ? mem0.nbad : mem1.nbad), 32'd0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule